// File: doc/BRIEF.md
# Two-Pass 4x4 Integer Forward Transform

The block turns a 4x4 tile of signed 16-bit residual samples into 16 signed 16-bit transform coefficients. The arithmetic is an exact integer transform used in video coding. It does not approximate a floating-point DCT, and every rounding constant and shift is fixed so that the results match a software encoder bit for bit. Rows of samples arrive one per cycle under a valid/ready handshake. A horizontal stage transforms each row as it arrives and writes the result into a two-bank transpose store. A vertical stage then transforms the columns with its own rounding and emits one coefficient row per cycle, in raster order.

A mode input picks one of two operations. In single mode a unit is one 4x4 tile. In wide mode a unit is two side-by-side tiles: each input beat carries eight samples, the left tile in the low half and the right tile in the high half. The left tile's 16 coefficients leave first and the right tile's 16 follow at once. Because the store has two banks, single-mode tiles can stream back to back with no gaps, and a new tile is accepted while the previous one drains.

Top module: `fwd_xform4x4`

## Requirements
- R1: Horizontal pass on row samples x0..x3: s = x0+x3, t = x1+x2, u = x1-x2, v = x0-x3. Coefficient 0 is (s+t)*8 and coefficient 2 is (s-t)*8.
- R2: Horizontal coefficient 1 is (u*2217 + v*5352 + 14500) >> 12 and coefficient 3 is (v*2217 - u*5352 + 7500) >> 12. All shifts are arithmetic.
- R3: Vertical pass on column entries y0..y3 (rows 0..3 of the horizontal result), with s, t, u, v formed as in R1. Output rows 0 and 2 are (s+t+7) >> 4 and (s-t+7) >> 4.
- R4: Vertical output row 1 is ((u*2217 + v*5352 + 12000) >> 16), plus 1 exactly when v is nonzero.
- R5: Vertical output row 3 is (v*2217 - u*5352 + 51000) >> 16.
- R6: In both passes, s, t, u and v saturate to the signed 16-bit range. Later products and sums are 32-bit. Every coefficient of either pass is truncated to its low 16 bits.
- R7: A row is taken when in_valid and in_ready are both high. Sample k of a tile row sits at in_row[16k+15:16k]. Output coefficient c of a row sits at out_row[16c+15:16c]. Output row 0 is valid on the second rising edge after the edge that takes the fourth input row.
- R8: With in_wide low when a unit starts, the unit is one tile: in_row[127:64] is ignored, and out_last is high on output row 3 only.
- R9: With in_wide high when a unit starts, the unit is four beats. Each beat carries the left-tile row in in_row[63:0] and the right-tile row in in_row[127:64]. The output is eight consecutive rows: the left tile's four first, then the right tile's four, with out_last high on the eighth row only. in_wide is sampled only on a unit's first beat.
- R10: Single-mode tiles sent back to back are all accepted with in_ready staying high, and their output rows follow each other with no gap.
- R11: A wide unit starts only when both store banks are empty. If it is offered right after a single tile, in_ready stays low for exactly the four cycles that tile takes to drain.
- R12: A synchronous reset clears out_valid and out_last and discards any partly received unit. The next row taken after reset is row 0 of a new unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block can take the offered row |
| in_wide | input | 1 | Mode: 0 single tile, 1 two side-by-side tiles (sampled on a unit's first beat) |
| in_row | input | 8*DW | Input samples, left tile low half, right tile high half |
| out_valid | output | 1 | Output row valid |
| out_last | output | 1 | Final row of the unit |
| out_row | output | 4*DW | Four output coefficients of one row |

## Verification
The bench builds the block with the default sample width DW = 16 only. That is the width for which the fixed constants and shifts give the exact codec result, so every expected value can be worked out directly from the formulas. At that width, inputs near ±32767 push the first-stage sums into saturation and push the horizontal DC term past 16 bits, so the clamp and the truncation are both exercised. Directed tiles cover zeros, ramps, low-amplitude and full-scale values, back-to-back streaming, wide units, a wide unit that has to wait for the banks to empty, and a reset in the middle of a tile.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
  localparam int ACC_W = 32;
  typedef logic signed [ACC_W-1:0] acc_t;

  // transform constants shared by both passes
  localparam int K_A      = 2217;
  localparam int K_B      = 5352;
  localparam int H_RND_1  = 14500;
  localparam int H_RND_3  = 7500;
  localparam int H_SH     = 12;
  localparam int H_EV_SH  = 3;
  localparam int V_RND_EV = 7;
  localparam int V_SH_EV  = 4;
  localparam int V_RND_1  = 12000;
  localparam int V_RND_3  = 51000;
  localparam int V_SH_OD  = 16;

  // clamp v into the signed range of w bits
  function automatic acc_t sat_to(input acc_t v, input int w);
    acc_t hi, lo;
    hi = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    lo = -hi - acc_t'(1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/fxf_hpass.sv
module fxf_hpass import fxf_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [4*DW-1:0] smp,
  output logic [4*DW-1:0] coef
);
  acc_t x0, x1, x2, x3;
  acc_t s, t, u, v;
  acc_t e0, e2, o1, o3;

  always_comb begin
    x0 = acc_t'(signed'(smp[0*DW +: DW]));
    x1 = acc_t'(signed'(smp[1*DW +: DW]));
    x2 = acc_t'(signed'(smp[2*DW +: DW]));
    x3 = acc_t'(signed'(smp[3*DW +: DW]));
    s  = sat_to(x0 + x3, DW);
    t  = sat_to(x1 + x2, DW);
    u  = sat_to(x1 - x2, DW);
    v  = sat_to(x0 - x3, DW);
    e0 = (s + t) <<< H_EV_SH;
    e2 = (s - t) <<< H_EV_SH;
    o1 = (u * K_A + v * K_B + H_RND_1) >>> H_SH;
    o3 = (v * K_A - u * K_B + H_RND_3) >>> H_SH;
    coef = {DW'(o3), DW'(e2), DW'(o1), DW'(e0)};
  end
endmodule

// File: rtl/fxf_vpass.sv
module fxf_vpass import fxf_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [4*DW-1:0] col,
  input  logic [1:0]      sel,
  output logic [DW-1:0]   y
);
  acc_t p0, p1, p2, p3;
  acc_t s, t, u, v;
  acc_t r0, r1, r2, r3;

  always_comb begin
    p0 = acc_t'(signed'(col[0*DW +: DW]));
    p1 = acc_t'(signed'(col[1*DW +: DW]));
    p2 = acc_t'(signed'(col[2*DW +: DW]));
    p3 = acc_t'(signed'(col[3*DW +: DW]));
    s  = sat_to(p0 + p3, DW);
    t  = sat_to(p1 + p2, DW);
    u  = sat_to(p1 - p2, DW);
    v  = sat_to(p0 - p3, DW);
    r0 = (s + t + V_RND_EV) >>> V_SH_EV;
    r2 = (s - t + V_RND_EV) >>> V_SH_EV;
    r1 = ((u * K_A + v * K_B + V_RND_1) >>> V_SH_OD) + ((v != 0) ? acc_t'(1) : acc_t'(0));
    r3 = (v * K_A - u * K_B + V_RND_3) >>> V_SH_OD;
    unique case (sel)
      2'd0:    y = DW'(r0);
      2'd1:    y = DW'(r1);
      2'd2:    y = DW'(r2);
      default: y = DW'(r3);
    endcase
  end
endmodule

// File: rtl/fxf_tstore.sv
module fxf_tstore #(
  parameter int DW = 16,
  parameter int N  = 4,
  parameter int NB = 2
) (
  input  logic                    clk,
  input  logic [NB-1:0]           we,
  input  logic [$clog2(N)-1:0]    wr_row,
  input  logic [NB*N*DW-1:0]      wr_data,
  input  logic [$clog2(NB)-1:0]   rd_bank,
  output logic [N*N*DW-1:0]       rd_data
);
  localparam int ROW_W = N * DW;

  logic [ROW_W-1:0] mem [NB*N];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we[b]) mem[b*N + int'(wr_row)] <= wr_data[b*ROW_W +: ROW_W];
    end
  end

  always_comb begin
    for (int r = 0; r < N; r++) begin
      rd_data[r*ROW_W +: ROW_W] = mem[int'(rd_bank)*N + r];
    end
  end
endmodule

// File: rtl/fwd_xform4x4.sv
module fwd_xform4x4 #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_wide,
  input  logic [8*DW-1:0] in_row,
  output logic            out_valid,
  output logic            out_last,
  output logic [4*DW-1:0] out_row
);
  localparam int N      = 4;
  localparam int NB     = 2;
  localparam int RW     = $clog2(N);
  localparam int HALF_W = N * DW;

  logic [RW-1:0]       in_cnt;
  logic                unit_wide;
  logic                wr_bank;
  logic [NB-1:0]       full, tail;
  logic                rd_bank;
  logic [RW-1:0]       rd_row;

  logic                start, wide_now, accept, unit_done, rd_go, rd_end;
  logic [NB-1:0]       we, full_set, full_clr;
  logic [HALF_W-1:0]   hcoef [2];
  logic [NB*HALF_W-1:0] wr_data;
  logic [N*N*DW-1:0]   rd_data;
  logic [HALF_W-1:0]   col_v [N];
  logic [HALF_W-1:0]   vrow;

  assign start     = (in_cnt == '0);
  assign wide_now  = start ? in_wide : unit_wide;
  assign in_ready  = start ? (in_wide ? (full == '0) : !full[wr_bank]) : 1'b1;
  assign accept    = in_valid && in_ready;
  assign unit_done = accept && (in_cnt == RW'(N-1));
  assign rd_go     = full[rd_bank];
  assign rd_end    = rd_go && (rd_row == RW'(N-1));

  // horizontal pass, one instance per tile half
  for (genvar h = 0; h < 2; h++) begin : g_h
    fxf_hpass #(.DW(DW)) u_hp (
      .smp  (in_row[h*HALF_W +: HALF_W]),
      .coef (hcoef[h])
    );
  end

  // bank steering: the left half goes to wr_bank, the right half to the other bank
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign we[b] = accept && ((1'(b) == wr_bank) || wide_now);
    assign wr_data[b*HALF_W +: HALF_W] = (1'(b) == wr_bank) ? hcoef[0] : hcoef[1];
    assign full_set[b] = unit_done && we[b];
    assign full_clr[b] = rd_end && (1'(b) == rd_bank);
  end

  fxf_tstore #(.DW(DW), .N(N), .NB(NB)) u_store (
    .clk     (clk),
    .we      (we),
    .wr_row  (in_cnt),
    .wr_data (wr_data),
    .rd_bank (rd_bank),
    .rd_data (rd_data)
  );

  // column gather for the vertical pass
  always_comb begin
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) begin
        col_v[c][r*DW +: DW] = rd_data[(r*N + c)*DW +: DW];
      end
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_v
    fxf_vpass #(.DW(DW)) u_vp (
      .col (col_v[c]),
      .sel (rd_row),
      .y   (vrow[c*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt    <= '0;
      unit_wide <= 1'b0;
      wr_bank   <= 1'b0;
      full      <= '0;
      tail      <= '0;
      rd_bank   <= 1'b0;
      rd_row    <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_row   <= '0;
    end else begin
      if (accept) begin
        in_cnt <= in_cnt + RW'(1);
        if (start) unit_wide <= in_wide;
      end
      if (unit_done) begin
        tail[wr_bank] <= !wide_now;
        if (wide_now) tail[~wr_bank] <= 1'b1;
        else          wr_bank        <= ~wr_bank;
      end
      full <= (full & ~full_clr) | full_set;
      if (rd_go) begin
        out_valid <= 1'b1;
        out_row   <= vrow;
        out_last  <= tail[rd_bank] && (rd_row == RW'(N-1));
        rd_row    <= rd_row + RW'(1);
        if (rd_end) rd_bank <= ~rd_bank;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  // checker state: rows emitted since the last unit end
  logic [3:0] rows_seen;
  always_ff @(posedge clk) begin
    if (rst)            rows_seen <= '0;
    else if (out_valid) rows_seen <= out_last ? 4'd0 : rows_seen + 4'd1;
  end

  p_last_in_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  p_reset_clears_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_last));

  p_no_overwrite_r10: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((we & full) == '0));

  p_unit_length_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (rows_seen == 4'd3 || rows_seen == 4'd7));
endmodule

// File: tb/test_fwd_xform4x4.sv
module test_fwd_xform4x4;
  typedef int blk_t [16];

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_wide = 1'b0;
  logic [127:0] in_row = '0;
  logic         in_ready, out_valid, out_last;
  logic [63:0]  out_row;

  always #4 clk = ~clk;

  fwd_xform4x4 #(.DW(16)) i_fwd_xform4x4 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_row(in_row), .out_valid(out_valid),
    .out_last(out_last), .out_row(out_row)
  );

  int checks = 0;
  int fails = 0;
  int stalls = 0;
  int samp_n = 0;
  int acc_at = 0;
  int cap_n = 0;
  int exp_n = 0;
  logic [63:0] cap_row [0:127];
  bit          cap_last [0:127];
  int          cap_at [0:127];
  logic [63:0] exp_row [0:127];
  bit          exp_last [0:127];

  // monitor: samples between the falling and the next rising edge
  always begin
    @(negedge clk);
    #2;
    if (in_valid && in_ready && !rst) acc_at = samp_n;
    if (out_valid && cap_n < 128) begin
      cap_row[cap_n]  = out_row;
      cap_last[cap_n] = out_last;
      cap_at[cap_n]   = samp_n;
      cap_n++;
    end
    samp_n++;
  end

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int tr(input int v);
    int t;
    t = v & 32'hFFFF;
    if (t > 32767) t = t - 65536;
    return t;
  endfunction

  function automatic void model(input blk_t s, output blk_t e);
    blk_t h;
    int a, b, c, d;
    for (int r = 0; r < 4; r++) begin
      a = sat(s[r*4+0] + s[r*4+3]);
      b = sat(s[r*4+1] + s[r*4+2]);
      c = sat(s[r*4+1] - s[r*4+2]);
      d = sat(s[r*4+0] - s[r*4+3]);
      h[r*4+0] = tr((a + b) * 8);
      h[r*4+1] = tr((c * 2217 + d * 5352 + 14500) >>> 12);
      h[r*4+2] = tr((a - b) * 8);
      h[r*4+3] = tr((d * 2217 - c * 5352 + 7500) >>> 12);
    end
    for (int k = 0; k < 4; k++) begin
      a = sat(h[k] + h[12+k]);
      b = sat(h[4+k] + h[8+k]);
      c = sat(h[4+k] - h[8+k]);
      d = sat(h[k] - h[12+k]);
      e[k]    = tr((a + b + 7) >>> 4);
      e[4+k]  = tr(((c * 2217 + d * 5352 + 12000) >>> 16) + ((d != 0) ? 1 : 0));
      e[8+k]  = tr((a - b + 7) >>> 4);
      e[12+k] = tr((d * 2217 - c * 5352 + 51000) >>> 16);
    end
  endfunction

  function automatic void fill(output blk_t s, input int seed, input int amp);
    int unsigned x;
    x = seed;
    for (int k = 0; k < 16; k++) begin
      x = x * 1103515245 + 12345;
      s[k] = int'((x >> 8) % (2 * amp + 1)) - amp;
    end
  endfunction

  function automatic logic [63:0] pack(input blk_t s, input int r);
    logic [63:0] p;
    for (int k = 0; k < 4; k++) p[k*16 +: 16] = 16'(s[r*4+k]);
    return p;
  endfunction

  task automatic check(input bit ok, input string what, input logic [64:0] act, input logic [64:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  task automatic clear();
    exp_n = 0;
    cap_n = 0;
    stalls = 0;
  endtask

  task automatic push(input blk_t e, input bit last);
    for (int r = 0; r < 4; r++) begin
      exp_row[exp_n]  = pack(e, r);
      exp_last[exp_n] = last && (r == 3);
      exp_n++;
    end
  endtask

  task automatic send_row(input logic [127:0] row, input logic wide);
    @(negedge clk);
    in_row = row;
    in_wide = wide;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_block(input blk_t s, input logic [63:0] junk);
    for (int r = 0; r < 4; r++) send_row({junk, pack(s, r)}, 1'b0);
  endtask

  task automatic send_wide(input blk_t l, input blk_t rt);
    for (int r = 0; r < 4; r++) send_row({pack(rt, r), pack(l, r)}, 1'b1);
  endtask

  task automatic compare(input string tag);
    check(cap_n == exp_n, {tag, " row count"}, 65'(cap_n), 65'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_row[i] == exp_row[i] && cap_last[i] == exp_last[i],
            $sformatf("%s row %0d {last,coefs}", tag, i),
            {cap_last[i], cap_row[i]}, {exp_last[i], exp_row[i]});
    end
  endtask

  // R12: state out of reset
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R12 out_valid during reset", 65'(out_valid), 65'(0));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0 && out_last == 1'b0, "R12 outputs idle after reset",
          65'({out_valid, out_last}), 65'(0));
    check(in_ready == 1'b1, "R12 ready after reset", 65'(in_ready), 65'(1));
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8: one tile in single mode, junk in the upper lanes
  task automatic t_single(input string tag, input blk_t s, input logic [63:0] junk);
    blk_t e;
    clear();
    model(s, e);
    push(e, 1'b1);
    send_block(s, junk);
    idle(10);
    compare({tag, " R1 R2 R3 R4 R5 R6 R8"});
    check(cap_at[0] == acc_at + 2, {tag, " R7 first row latency"}, 65'(cap_at[0]), 65'(acc_at + 2));
  endtask

  // R9: wide unit, left tile then right tile
  task automatic t_wide();
    blk_t l, rt, el, er;
    clear();
    fill(l, 11, 3000);
    fill(rt, 29, 255);
    model(l, el);
    model(rt, er);
    push(el, 1'b0);
    push(er, 1'b1);
    send_wide(l, rt);
    idle(14);
    compare("R9 wide unit");
    check(cap_at[7] - cap_at[0] == 7, "R9 rows contiguous", 65'(cap_at[7] - cap_at[0]), 65'(7));
  endtask

  // R10: three single tiles streamed back to back
  task automatic t_stream();
    blk_t s, e;
    clear();
    for (int k = 0; k < 3; k++) begin
      fill(s, 100 + k, 1000);
      model(s, e);
      push(e, 1'b1);
      send_block(s, 64'h0);
    end
    idle(12);
    check(stalls == 0, "R10 no stall when streaming", 65'(stalls), 65'(0));
    compare("R10 stream");
    check(cap_at[11] - cap_at[0] == 11, "R10 output gapless", 65'(cap_at[11] - cap_at[0]), 65'(11));
  endtask

  // R11: a wide unit right after a single tile waits for the drain
  task automatic t_wide_wait();
    blk_t a, l, rt, ea, el, er;
    clear();
    fill(a, 7, 500);
    fill(l, 8, 500);
    fill(rt, 9, 500);
    model(a, ea);
    model(l, el);
    model(rt, er);
    push(ea, 1'b1);
    push(el, 1'b0);
    push(er, 1'b1);
    send_block(a, 64'h0);
    send_wide(l, rt);
    idle(14);
    check(stalls == 4, "R11 wide start stall cycles", 65'(stalls), 65'(4));
    compare("R11 mixed units");
  endtask

  // R12: reset in the middle of a tile discards it
  task automatic t_reset_mid();
    blk_t junkb, s, e;
    clear();
    fill(junkb, 55, 20000);
    send_row({64'h0, pack(junkb, 0)}, 1'b0);
    send_row({64'h0, pack(junkb, 1)}, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(cap_n == 0, "R12 no output from partial tile", 65'(cap_n), 65'(0));
    fill(s, 77, 600);
    model(s, e);
    push(e, 1'b1);
    send_block(s, 64'h0);
    idle(10);
    compare("R12 after mid reset");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    blk_t s;
    t_reset();
    for (int k = 0; k < 16; k++) s[k] = 0;
    t_single("zeros", s, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int k = 0; k < 16; k++) s[k] = k * 3 - 20;
    t_single("ramp", s, 64'h1234_5678_9ABC_DEF0);
    fill(s, 3, 200);
    t_single("small", s, 64'hA5A5_5A5A_A5A5_5A5A);
    fill(s, 4, 32767);
    t_single("fullscale", s, 64'h0);
    for (int k = 0; k < 16; k++) s[k] = 32767;
    t_single("max", s, 64'h0);
    for (int k = 0; k < 16; k++) s[k] = ((k + k / 4) % 2 == 0) ? 32767 : -32768;
    t_single("checker", s, 64'h0);
    t_wide();
    t_stream();
    t_wide_wait();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule